// File: doc/BRIEF.md
# Retriggerable Dual-Compare Timer Channel

This block is one 16-bit timer channel. A count register climbs toward a terminal value held in one of two compare registers, A or B. Two mode bits decide what advances the count: a plain internal clock gated by the input pin, an internal clock that each rising pin edge restarts, or the pin's own rising edges used as the clock. The pin is synchronised by two flops and then edge-detected before any mode logic sees it. The channel runs one cycle and stops, or it runs continuously. In single-compare operation it uses only A. In dual-compare operation it alternates between A and B.

The output pin has two forms. In single-compare operation it idles high and drops for exactly one clock at the end of each cycle. In dual-compare operation it is a level: high while A is the active compare, low while B is. In both forms the output moves one clock after the counter state that causes it.

Software programs the channel through a plain write port: an enable, an address and a data word. There is no back-pressure on this port. A write lands on the clock edge where the enable is sampled high. No data stream passes through the block, so no port uses a valid/ready handshake.

Top module: `rtg_timer`

## Requirements
- R1: While reset is held and directly after it, `tmr_out` is 1 and `count` is 0. Both `b_active` and `running` are 0.
- R2: With ext=0 and rtg=0, the count rises by one on each clock in which the synchronised pin is high, and holds while it is low. A pin rise seen after edge e first shows as a count of 1 after edge e+3.
- R3: With ext=0 and rtg=1, nothing is counted after a control write until the first rising pin edge. That edge shows as a count of 0 after edge e+3, where e is the edge the pin rise follows. After that the count rises every clock.
- R4: With ext=0 and rtg=1, every later rising pin edge sets the count back to 0 and restarts the timing cycle.
- R5: With ext=1, the rtg bit is ignored. Each rising pin edge adds one to the count, and a pin held high adds only one.
- R6: When a count event arrives while the count equals the active compare value (A, or B when `b_active` is 1 in dual operation), the count returns to 0 on that edge. A cycle therefore lasts compare+1 count events.
- R7: In single-compare operation, `tmr_out` is low for exactly one clock. That clock is the one after the edge where the count returned to 0, so `count` reads 1 during the low clock when events arrive every clock.
- R8: In dual-compare operation, `b_active` flips at each cycle end. `tmr_out` equals the inverse of `b_active` one clock later.
- R9: In dual-compare operation, a retrigger edge zeroes the count but leaves `b_active` unchanged. The next flip happens only after counting from 0 up to the compare value in use.
- R10: With the continuous bit set, the channel restarts by itself. With it clear, `running` drops at the end of cycle A in single operation, or at the end of cycle B in dual operation.
- R11: The write port decodes `cfg_addr` as 0 for compare A, 1 for compare B and 2 for control; address 3 is ignored. The control bits are [0] run, [1] continuous, [2] ext, [3] rtg and [4] dual. A control write zeroes the count, selects A and clears the retrigger arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for the configuration port |
| cfg_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 control |
| cfg_wdata | input | 16 | Write data |
| trig_in | input | 1 | Asynchronous timer input pin |
| tmr_out | output | 1 | Timer output pin: one-clock low pulse or compare-in-use level |
| count | output | 16 | Current count value |
| b_active | output | 1 | 1 while compare B is the active terminal value |
| running | output | 1 | Channel enabled |

## Verification
The counting function is driven with four pin patterns. A long high level against a low level separates gated counting from free counting. A single pulse after enable shows whether retrigger mode really waits to be armed. A pulse in the middle of a cycle checks that the count is zeroed while the compare in use stays put. A train of short pulses, followed by a long high level, shows that external clocking counts edges and not levels. Each pattern is run in single and dual operation, and continuous and one-shot runs are compared. Exact output timelines then separate a one-clock pulse from a level, and an off-by-one terminal count from a correct one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ADDR_CMP_A = 2'd0,
    ADDR_CMP_B = 2'd1,
    ADDR_CTRL  = 2'd2
  } cfg_addr_e;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_CONT = 1;
  localparam int unsigned BIT_EXT  = 2;
  localparam int unsigned BIT_RTG  = 3;
  localparam int unsigned BIT_DUAL = 4;

  typedef struct packed {
    logic dual;
    logic rtg;
    logic ext;
    logic cont;
  } tmr_mode_t;

  typedef enum logic [1:0] {
    SRC_GATED,
    SRC_RETRIG,
    SRC_EXTERNAL
  } tick_src_e;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b,
  output tmr_mode_t    mode,
  output logic         ctrl_wr,
  output logic         run_wr
);
  logic wr_a, wr_b;

  always_comb begin
    wr_a    = we && (cfg_addr_e'(addr) == ADDR_CMP_A);
    wr_b    = we && (cfg_addr_e'(addr) == ADDR_CMP_B);
    ctrl_wr = we && (cfg_addr_e'(addr) == ADDR_CTRL);
    run_wr  = wdata[BIT_RUN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
      mode  <= '0;
    end else begin
      if (wr_a) cmp_a <= wdata;
      if (wr_b) cmp_b <= wdata;
      if (ctrl_wr) begin
        mode.dual <= wdata[BIT_DUAL];
        mode.rtg  <= wdata[BIT_RTG];
        mode.ext  <= wdata[BIT_EXT];
        mode.cont <= wdata[BIT_CONT];
      end
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_t    mode,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         ctrl_wr,
  input  logic         run_wr,
  input  logic         pin_level,
  input  logic         pin_rise,
  output logic [W-1:0] cnt,
  output logic         riu,
  output logic         run,
  output logic         armed,
  output logic         term
);
  tick_src_e    src;
  logic         tick;
  logic         retrig;
  logic [W-1:0] cmp_act;
  logic         last_phase;

  always_comb begin
    if (mode.ext)      src = SRC_EXTERNAL;
    else if (mode.rtg) src = SRC_RETRIG;
    else               src = SRC_GATED;

    unique case (src)
      SRC_EXTERNAL: tick = pin_rise;
      SRC_RETRIG:   tick = armed;
      default:      tick = pin_level;
    endcase

    retrig     = (src == SRC_RETRIG) && pin_rise;
    cmp_act    = (mode.dual && riu) ? cmp_b : cmp_a;
    last_phase = !mode.dual || riu;
    term       = run && !ctrl_wr && !retrig && tick && (cnt == cmp_act);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      riu   <= 1'b0;
      run   <= 1'b0;
      armed <= 1'b0;
    end else if (ctrl_wr) begin
      cnt   <= '0;
      riu   <= 1'b0;
      armed <= 1'b0;
      run   <= run_wr;
    end else if (run) begin
      if (retrig) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (term) begin
        cnt <= '0;
        if (mode.dual) riu <= ~riu;
        if (!mode.cont && last_phase) run <= 1'b0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_t mode,
  input  logic      term,
  input  logic      riu,
  output logic      out_pin
);
  logic term_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_q  <= 1'b0;
      out_pin <= 1'b1;
    end else begin
      term_q  <= term;
      out_pin <= mode.dual ? ~riu : ~term_q;
    end
  end
endmodule

// File: rtl/rtg_timer.sv
module rtg_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         trig_in,
  output logic         tmr_out,
  output logic [W-1:0] count,
  output logic         b_active,
  output logic         running
);
  tmr_mode_t    mode;
  logic [W-1:0] cmp_a, cmp_b;
  logic         ctrl_wr, run_wr;
  logic         pin_level, pin_rise;
  logic         armed, term;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_in),
    .level(pin_level), .rise(pin_rise)
  );

  tmr_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode(mode), .ctrl_wr(ctrl_wr), .run_wr(run_wr)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .ctrl_wr(ctrl_wr), .run_wr(run_wr), .pin_level(pin_level), .pin_rise(pin_rise),
    .cnt(count), .riu(b_active), .run(running), .armed(armed), .term(term)
  );

  tmr_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .term(term), .riu(b_active),
    .out_pin(tmr_out)
  );
endmodule

// File: rtl/rtg_timer_chk.sv
module rtg_timer_chk
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input tmr_mode_t    mode,
  input logic         running,
  input logic         b_active,
  input logic         armed,
  input logic         term,
  input logic         pin_rise,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_a,
  input logic         tmr_out
);
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (count == '0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_out && !mode.dual && (cmp_a != '0) && !cfg_we) |=> tmr_out);

  a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode.dual) |-> (tmr_out == !$past(b_active)));

  a_r9_retrig_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rise && mode.rtg && !mode.ext && running && !cfg_we) |=> $stable(b_active));

  a_r10_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !mode.cont && (!mode.dual || b_active) && !cfg_we) |=> !running);

  a_r3_wait_for_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.rtg && !mode.ext && !armed && !pin_rise && !cfg_we) |=> $stable(count));
endmodule

bind rtg_timer rtg_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode(mode), .running(running),
  .b_active(b_active), .armed(armed), .term(term), .pin_rise(pin_rise),
  .count(count), .cmp_a(cmp_a), .tmr_out(tmr_out)
);

// File: tb/rtg_timer_tb_top.sv
module rtg_timer_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic         trig_in = 1'b0;
  logic         tmr_out;
  logic [W-1:0] count;
  logic         b_active;
  logic         running;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rtg_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .tmr_out(tmr_out),
    .count(count), .b_active(b_active), .running(running)
  );

  // control word bits: [0] run [1] cont [2] ext [3] rtg [4] dual
  localparam logic [W-1:0] C_RUN = 16'h0001, C_CONT = 16'h0002,
                           C_EXT = 16'h0004, C_RTG  = 16'h0008, C_DUAL = 16'h0010;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_pin();
    trig_in = 1'b1;
    step(2);
    trig_in = 1'b0;
  endtask

  task automatic t_reset();
    check(tmr_out == 1'b1, "R1 out", int'(tmr_out), 1);
    check(count == 0, "R1 count", int'(count), 0);
    check(b_active == 1'b0 && running == 1'b0, "R1 flags",
          int'({b_active, running}), 0);
  endtask

  task automatic t_gated();
    int c;
    trig_in = 1'b0;
    wr(2'd0, 16'd1000);
    wr(2'd2, C_RUN | C_CONT);
    step(10);
    check(count == 0, "R2 pin low holds", int'(count), 0);
    trig_in = 1'b1;
    step(8);
    check(count == 6, "R2 gated count", int'(count), 6);
    trig_in = 1'b0;
    step(5);
    c = int'(count);
    step(10);
    check(int'(count) == c && c == 8, "R2 gate closed", int'(count), 8);
  endtask

  task automatic t_single_cont();
    int bad = 0;
    int lows = 0;
    trig_in = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd4);
    step(5);
    wr(2'd2, C_RUN | C_CONT);
    for (int i = 1; i <= 40; i++) begin
      bit exp_low;
      step(1);
      exp_low = (i >= 6) && (((i - 6) % 5) == 0);
      if (tmr_out == exp_low) bad++;
      if (!tmr_out) begin
        lows++;
        if (count != 1) bad++;
      end
    end
    check(bad == 0, "R7 R6 pulse timeline", bad, 0);
    check(lows == 7, "R10 continuous pulses", lows, 7);
    trig_in = 1'b0;
  endtask

  task automatic t_single_oneshot();
    int lows = 0;
    trig_in = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd3);
    step(4);
    wr(2'd2, C_RUN);
    for (int i = 1; i <= 20; i++) begin
      step(1);
      if (!tmr_out) lows++;
    end
    check(lows == 1, "R10 one pulse", lows, 1);
    check(running == 1'b0 && count == 0, "R10 single stop", int'(count), 0);
    trig_in = 1'b0;
  endtask

  task automatic t_dual_cont();
    int bad = 0;
    trig_in = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd5);
    step(4);
    wr(2'd2, C_RUN | C_CONT | C_DUAL);
    for (int i = 1; i <= 40; i++) begin
      bit exp_out;
      step(1);
      exp_out = (i < 5) ? 1'b1 : (((i - 5) % 10) >= 6);
      if (tmr_out != exp_out) bad++;
      if (i == 4 && b_active != 1'b1) bad++;
    end
    check(bad == 0, "R8 level timeline", bad, 0);
    trig_in = 1'b0;
  endtask

  task automatic t_dual_oneshot();
    trig_in = 1'b1;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd2);
    step(4);
    wr(2'd2, C_RUN | C_DUAL);
    step(4);
    check(b_active == 1'b1 && tmr_out == 1'b0, "R8 B in use", int'(tmr_out), 0);
    step(1);
    check(running == 1'b1, "R10 dual runs through B", int'(running), 1);
    step(1);
    check(running == 1'b0 && b_active == 1'b0, "R10 dual stop after B",
          int'({running, b_active}), 0);
    step(4);
    check(tmr_out == 1'b1 && count == 0, "R10 dual idle", int'(count), 0);
    trig_in = 1'b0;
  endtask

  task automatic t_retrig_single();
    trig_in = 1'b0;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd1000);
    step(4);
    wr(2'd2, C_RUN | C_CONT | C_RTG);
    step(10);
    check(count == 0, "R3 unarmed", int'(count), 0);
    pulse_pin();
    step(8);
    check(count == 7, "R3 armed count", int'(count), 7);
    step(10);
    pulse_pin();
    step(1);
    check(count == 0, "R4 retrigger zero", int'(count), 0);
    step(7);
    check(count == 7, "R4 restart", int'(count), 7);
  endtask

  task automatic t_retrig_dual();
    trig_in = 1'b0;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd50);
    step(4);
    wr(2'd2, C_RUN | C_CONT | C_RTG | C_DUAL);
    pulse_pin();
    step(5);
    check(b_active == 1'b1 && count == 0, "R9 A ended", int'(count), 0);
    step(5);
    pulse_pin();
    step(1);
    check(b_active == 1'b1 && count == 0, "R9 retrig keeps B", int'(b_active), 1);
    step(7);
    check(count == 7 && b_active == 1'b1, "R9 counting B", int'(count), 7);
    step(43);
    check(count == 50 && b_active == 1'b1, "R9 at B max", int'(count), 50);
    step(1);
    check(count == 0 && b_active == 1'b0, "R9 B ended", int'(b_active), 0);
  endtask

  task automatic t_external();
    trig_in = 1'b0;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd100);
    step(4);
    wr(2'd2, C_RUN | C_CONT | C_EXT | C_RTG);
    step(6);
    check(count == 0, "R5 no edges", int'(count), 0);
    for (int k = 0; k < 5; k++) begin
      pulse_pin();
      step(2);
    end
    step(4);
    check(count == 5, "R5 edge count", int'(count), 5);
    trig_in = 1'b1;
    step(10);
    check(count == 6, "R5 level counts once", int'(count), 6);
    trig_in = 1'b0;
  endtask

  task automatic t_cfg_decode();
    int c;
    wr(2'd2, C_RUN | C_CONT);
    trig_in = 1'b1;
    step(8);
    trig_in = 1'b0;
    step(4);
    c = int'(count);
    wr(2'd3, C_DUAL | C_EXT);
    step(3);
    check(int'(count) == c && running, "R11 addr 3 ignored", int'(count), c);
    wr(2'd2, C_RUN);
    check(count == 0 && b_active == 1'b0, "R11 ctrl write clears", int'(count), 0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_gated();
    t_single_cont();
    t_single_oneshot();
    t_dual_cont();
    t_dual_oneshot();
    t_retrig_single();
    t_retrig_dual();
    t_external();
    t_cfg_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule